// File: doc/BRIEF.md
# Power-on semi-suspend reset sequencer

This block keeps a microcontroller core parked after power comes up, while the oscillator and every peripheral keep running. It watches a synchronous supply-good level and an oscillator-stable level. Once both are good, it times a two-phase hold from a one-cycle millisecond tick. The first phase is a short window that nothing can break. The second, longer window ends early when an upstream bus-reset detect pulse arrives. An early exit also leaves a bus-reset interrupt pending for firmware.

While supply-good is low the block is in power-on reset. All its state clears and a sticky power-on cause flag is set. A later loss of supply restarts the whole sequence. When the hold ends, a one-cycle start strobe tells the core to begin fetching from address zero. The pending interrupt reaches the core only when its own enable and the global interrupt enable are both set.

Top module: `por_semisuspend_seq`

## Requirements
- R1: In the cycle after `supply_ok` is sampled low, `por_active`, `cpu_hold` and `por_flag` are 1, `bus_irq_pending` is 0 and the tick count is cleared.
- R2: Power-on reset ends only at the first edge where `supply_ok` and `osc_stable` are both 1. Until then `cpu_hold` stays 1 and ticks are not counted.
- R3: During the first LOCK_MS ticks of the hold, a `bus_reset_det` pulse has no effect: `cpu_hold` stays 1 and `bus_irq_pending` stays 0.
- R4: With no bus reset, `cpu_hold` falls in the cycle after the (LOCK_MS+WAIT_MS)-th tick counted since power-on reset ended. After that it stays 0 until supply is lost.
- R5: A `bus_reset_det` pulse after the first LOCK_MS ticks, while the hold is still on, clears `cpu_hold` in the next cycle and sets `bus_irq_pending`.
- R6: When a bus reset and the final tick of the second window fall in the same cycle, the outcome is an early exit: the hold is released and `bus_irq_pending` is set.
- R7: `cpu_start` is 1 for exactly the first cycle in which `cpu_hold` is 0, and that cycle is the start of execution at address 0.
- R8: `bus_irq_req` equals `bus_irq_pending & bus_irq_en & global_ie`. `irq_ack` clears the pending bit in the next cycle, and a bus reset in the same cycle as `irq_ack` keeps it set.
- R9: `por_flag` stays 1 after power-on reset until `por_flag_clr` is pulsed, and it is set again by any later power-on reset.
- R10: After release, each `bus_reset_det` pulse sets `bus_irq_pending`.
- R11: Losing supply in any phase restarts the full sequence, including the non-interruptible window and the full tick count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| supply_ok | input | 1 | Supply-good level, synchronous; low means power-on reset |
| osc_stable | input | 1 | Oscillator and PLL stable level |
| ms_tick | input | 1 | One-cycle pulse every millisecond |
| bus_reset_det | input | 1 | One-cycle upstream bus-reset detect |
| bus_irq_en | input | 1 | Bus-reset interrupt enable bit |
| global_ie | input | 1 | Global interrupt enable |
| irq_ack | input | 1 | Clears the pending bus-reset interrupt |
| por_flag_clr | input | 1 | Clears the power-on cause flag |
| cpu_hold | output | 1 | Holds the CPU while 1 |
| cpu_start | output | 1 | One-cycle strobe: begin execution at address 0 |
| por_active | output | 1 | Power-on reset in force |
| por_flag | output | 1 | Sticky power-on reset cause |
| bus_irq_pending | output | 1 | Bus-reset interrupt pending |
| bus_irq_req | output | 1 | Pending interrupt passed by both enables |

## Verification
Two events can meet in the second hold window: the tick that would end the hold normally and a bus-reset pulse that ends it early. The bench sweeps the bus-reset pulse across every tick position of a scaled-down hold, with one extra run that drives it together with the final tick. For each run it works out, from the position alone, whether the pulse must be ignored, release at once, or be overtaken by the normal timeout. It checks the result through `cpu_hold`, `cpu_start` and `bus_irq_pending`. A second collision, acknowledge against a new bus reset on the pending bit, is driven in a single cycle and judged by the bit's next value.

// File: rtl/sss_pkg.sv
package sss_pkg;
  typedef enum logic [1:0] {
    PH_POR  = 2'd0,
    PH_LOCK = 2'd1,
    PH_WAIT = 2'd2,
    PH_RUN  = 2'd3
  } phase_t;

  // true when one more tick brings the count to the limit
  function automatic logic limit_hit(input logic [15:0] cnt, input logic [15:0] lim);
    return (cnt + 16'd1) == lim;
  endfunction

  function automatic int unsigned cnt_width(input int unsigned a, input int unsigned b);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m < 2) ? 1 : $clog2(m + 1);
  endfunction
endpackage

// File: rtl/ms_phase_counter.sv
module ms_phase_counter #(
  parameter int CW = 7
) (
  input  logic          clk,
  input  logic          clear,
  input  logic          tick,
  input  logic [CW-1:0] limit,
  output logic [CW-1:0] count,
  output logic          reach
);
  import sss_pkg::*;

  assign reach = tick && limit_hit(16'(count), 16'(limit));

  always_ff @(posedge clk) begin
    if (clear)      count <= '0;
    else if (reach) count <= '0;
    else if (tick)  count <= count + 1'b1;
  end
endmodule

// File: rtl/phase_ctrl.sv
module phase_ctrl (
  input  logic            clk,
  input  logic            supply_ok,
  input  logic            osc_stable,
  input  logic            bus_reset_det,
  input  logic            lock_reach,
  input  logic            wait_reach,
  output sss_pkg::phase_t phase,
  output logic            early_exit
);
  import sss_pkg::*;

  // bus reset wins over a coincident final tick
  assign early_exit = (phase == PH_WAIT) && bus_reset_det;

  always_ff @(posedge clk) begin
    if (!supply_ok) phase <= PH_POR;
    else begin
      unique case (phase)
        PH_POR:  if (osc_stable) phase <= PH_LOCK;
        PH_LOCK: if (lock_reach) phase <= PH_WAIT;
        PH_WAIT: if (early_exit || wait_reach) phase <= PH_RUN;
        default: phase <= PH_RUN;
      endcase
    end
  end
endmodule

// File: rtl/bus_irq_flag.sv
module bus_irq_flag (
  input  logic clk,
  input  logic clear_all,
  input  logic set_evt,
  input  logic ack,
  input  logic en,
  input  logic gie,
  output logic pending,
  output logic req
);
  assign req = pending & en & gie;

  always_ff @(posedge clk) begin
    if (clear_all)    pending <= 1'b0;
    else if (set_evt) pending <= 1'b1;
    else if (ack)     pending <= 1'b0;
  end
endmodule

// File: rtl/por_semisuspend_seq.sv
module por_semisuspend_seq #(
  parameter int LOCK_MS = 1,
  parameter int WAIT_MS = 95
) (
  input  logic clk,
  input  logic supply_ok,
  input  logic osc_stable,
  input  logic ms_tick,
  input  logic bus_reset_det,
  input  logic bus_irq_en,
  input  logic global_ie,
  input  logic irq_ack,
  input  logic por_flag_clr,
  output logic cpu_hold,
  output logic cpu_start,
  output logic por_active,
  output logic por_flag,
  output logic bus_irq_pending,
  output logic bus_irq_req
);
  import sss_pkg::*;

  localparam int CW = cnt_width(LOCK_MS, WAIT_MS);

  phase_t        phase;
  logic [CW-1:0] ms_count;
  logic [CW-1:0] ms_limit;
  logic          reach, lock_reach, wait_reach;
  logic          in_lock, in_wait, in_hold;
  logic          early_exit, irq_set, was_run;

  assign in_lock    = (phase == PH_LOCK);
  assign in_wait    = (phase == PH_WAIT);
  assign in_hold    = in_lock || in_wait;
  assign ms_limit   = in_wait ? CW'(WAIT_MS) : CW'(LOCK_MS);
  assign lock_reach = reach && in_lock;
  assign wait_reach = reach && in_wait;
  assign irq_set    = bus_reset_det && (in_wait || phase == PH_RUN);

  ms_phase_counter #(.CW(CW)) u_cnt (
    .clk   (clk),
    .clear (!supply_ok || !in_hold),
    .tick  (ms_tick),
    .limit (ms_limit),
    .count (ms_count),
    .reach (reach)
  );

  phase_ctrl u_ctrl (
    .clk           (clk),
    .supply_ok     (supply_ok),
    .osc_stable    (osc_stable),
    .bus_reset_det (bus_reset_det),
    .lock_reach    (lock_reach),
    .wait_reach    (wait_reach),
    .phase         (phase),
    .early_exit    (early_exit)
  );

  bus_irq_flag u_irq (
    .clk       (clk),
    .clear_all (!supply_ok),
    .set_evt   (irq_set),
    .ack       (irq_ack),
    .en        (bus_irq_en),
    .gie       (global_ie),
    .pending   (bus_irq_pending),
    .req       (bus_irq_req)
  );

  always_ff @(posedge clk) begin
    if (!supply_ok) begin
      was_run  <= 1'b0;
      por_flag <= 1'b1;
    end else begin
      was_run <= (phase == PH_RUN);
      if (por_flag_clr) por_flag <= 1'b0;
    end
  end

  assign por_active = (phase == PH_POR);
  assign cpu_hold   = (phase != PH_RUN);
  assign cpu_start  = (phase == PH_RUN) && !was_run;
endmodule

// File: rtl/sss_checker.sv
module sss_checker (
  input logic clk,
  input logic supply_ok,
  input logic bus_reset_det,
  input logic cpu_hold,
  input logic cpu_start,
  input logic por_active,
  input logic por_flag,
  input logic bus_irq_pending,
  input logic bus_irq_req,
  input logic in_lock,
  input logic early_exit
);
  assert_supply_loss_R1: assert property (@(posedge clk)
    !supply_ok |=> por_active && cpu_hold && por_flag && !bus_irq_pending);

  assert_hold_in_por_R2: assert property (@(posedge clk) disable iff (!supply_ok)
    por_active |-> cpu_hold);

  assert_lock_ignores_R3: assert property (@(posedge clk) disable iff (!supply_ok)
    in_lock && bus_reset_det |=> cpu_hold && !bus_irq_pending);

  assert_release_sticky_R4: assert property (@(posedge clk) disable iff (!supply_ok)
    !cpu_hold |=> !cpu_hold);

  assert_early_release_R5: assert property (@(posedge clk) disable iff (!supply_ok)
    early_exit |=> !cpu_hold && bus_irq_pending && cpu_start);

  assert_start_single_R7: assert property (@(posedge clk) disable iff (!supply_ok)
    cpu_start |=> !cpu_start);

  assert_req_needs_pending_R8: assert property (@(posedge clk) disable iff (!supply_ok)
    bus_irq_req |-> bus_irq_pending);
endmodule

bind por_semisuspend_seq sss_checker u_sss_chk (
  .clk             (clk),
  .supply_ok       (supply_ok),
  .bus_reset_det   (bus_reset_det),
  .cpu_hold        (cpu_hold),
  .cpu_start       (cpu_start),
  .por_active      (por_active),
  .por_flag        (por_flag),
  .bus_irq_pending (bus_irq_pending),
  .bus_irq_req     (bus_irq_req),
  .in_lock         (in_lock),
  .early_exit      (early_exit)
);

// File: tb/sim_por_semisuspend_seq.sv
module sim_por_semisuspend_seq;
  localparam int L = 2;
  localparam int W = 6;
  localparam int TOTAL = L + W;

  logic clk = 1'b0;
  logic supply_ok = 1'b0, osc_stable = 1'b0, ms_tick = 1'b0, bus_reset_det = 1'b0;
  logic bus_irq_en = 1'b0, global_ie = 1'b0, irq_ack = 1'b0, por_flag_clr = 1'b0;
  logic cpu_hold, cpu_start, por_active, por_flag, bus_irq_pending, bus_irq_req;

  int total = 0;
  int bad = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  por_semisuspend_seq #(.LOCK_MS(L), .WAIT_MS(W)) u0 (
    .clk(clk), .supply_ok(supply_ok), .osc_stable(osc_stable), .ms_tick(ms_tick),
    .bus_reset_det(bus_reset_det), .bus_irq_en(bus_irq_en), .global_ie(global_ie),
    .irq_ack(irq_ack), .por_flag_clr(por_flag_clr), .cpu_hold(cpu_hold),
    .cpu_start(cpu_start), .por_active(por_active), .por_flag(por_flag),
    .bus_irq_pending(bus_irq_pending), .bus_irq_req(bus_irq_req)
  );

  task automatic check(input logic act, input logic exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  // one cycle with the given pulses; results sampled at the following negedge
  task automatic step(input logic tk, input logic br);
    @(negedge clk);
    ms_tick = tk; bus_reset_det = br;
    @(negedge clk);
    ms_tick = 1'b0; bus_reset_det = 1'b0;
  endtask

  task automatic power_up();
    @(negedge clk);
    supply_ok = 1'b0; osc_stable = 1'b0;
    repeat (2) @(negedge clk);
    check(por_active, 1'b1, "R1 por_active in reset");
    check(cpu_hold, 1'b1, "R1 hold in reset");
    check(bus_irq_pending, 1'b0, "R1 pending cleared");
    check(por_flag, 1'b1, "R1 por_flag set");
    supply_ok = 1'b1;
    step(1'b1, 1'b0);
    check(por_active, 1'b1, "R2 osc not stable keeps por");
    @(negedge clk);
    osc_stable = 1'b1;
    @(negedge clk);
    check(por_active, 1'b0, "R2 por released");
    check(cpu_hold, 1'b1, "R2 still holding");
  endtask

  // k: ticks before the bus reset pulse; k == TOTAL means none; k < 0 means with final tick
  task automatic run_case(input int k);
    bit released;
    released = 1'b0;
    power_up();
    for (int t = 0; t < TOTAL; t++) begin
      if (k == t && t < L) begin
        step(1'b0, 1'b1);
        check(cpu_hold, 1'b1, "R3 bus reset in lock ignored");
        check(bus_irq_pending, 1'b0, "R3 no pending from lock");
      end else if (k == t) begin
        step(1'b0, 1'b1);
        check(cpu_hold, 1'b0, "R5 early release");
        check(bus_irq_pending, 1'b1, "R5 pending set");
        check(cpu_start, 1'b1, "R7 start strobe");
        released = 1'b1;
        break;
      end
      if (k < 0 && t == TOTAL - 1) begin
        step(1'b1, 1'b1);
        check(cpu_hold, 1'b0, "R6 coincident release");
        check(bus_irq_pending, 1'b1, "R6 bus reset wins");
        released = 1'b1;
        break;
      end
      step(1'b1, 1'b0);
      check(cpu_hold, (t == TOTAL - 1) ? 1'b0 : 1'b1, "R4 hold vs tick count");
      if (t == TOTAL - 1) begin
        check(cpu_start, 1'b1, "R7 start after timeout");
        check(bus_irq_pending, 1'b0, "R4 no pending on timeout");
        released = 1'b1;
      end
    end
    @(negedge clk);
    check(cpu_start, 1'b0, "R7 strobe one cycle");
    check(cpu_hold, !released, "R4 release sticky");
  endtask

  initial begin
    for (int k = 0; k <= TOTAL; k++) run_case(k);
    run_case(-1);

    // R8 gating and ack
    bus_irq_en = 1'b0; global_ie = 1'b1; #1;
    check(bus_irq_req, 1'b0, "R8 enable off");
    bus_irq_en = 1'b1; global_ie = 1'b0; #1;
    check(bus_irq_req, 1'b0, "R8 gie off");
    global_ie = 1'b1; #1;
    check(bus_irq_req, 1'b1, "R8 both enables");
    @(negedge clk); irq_ack = 1'b1; bus_reset_det = 1'b1;
    @(negedge clk); irq_ack = 1'b0; bus_reset_det = 1'b0;
    check(bus_irq_pending, 1'b1, "R8 set wins over ack");
    @(negedge clk); irq_ack = 1'b1;
    @(negedge clk); irq_ack = 1'b0;
    check(bus_irq_pending, 1'b0, "R8 ack clears");
    check(bus_irq_req, 1'b0, "R8 req drops");
    step(1'b0, 1'b1);
    check(bus_irq_pending, 1'b1, "R10 bus reset after release");

    // R9 flag clear and re-set
    @(negedge clk); por_flag_clr = 1'b1;
    @(negedge clk); por_flag_clr = 1'b0;
    check(por_flag, 1'b0, "R9 flag cleared");
    step(1'b1, 1'b0);
    check(por_flag, 1'b0, "R9 flag stays clear");

    // R11 supply loss mid-wait restarts full count
    power_up();
    for (int t = 0; t < L + 2; t++) step(1'b1, 1'b0);
    @(negedge clk); supply_ok = 1'b0;
    @(negedge clk);
    check(por_active, 1'b1, "R11 por on loss");
    check(por_flag, 1'b1, "R9 flag set again");
    supply_ok = 1'b1;
    @(negedge clk);
    for (int t = 0; t < L; t++) begin
      step(1'b0, 1'b1);
      check(cpu_hold, 1'b1, "R11 lock window restored");
      step(1'b1, 1'b0);
    end
    for (int t = L; t < TOTAL; t++) begin
      step(1'b1, 1'b0);
      check(cpu_hold, (t == TOTAL - 1) ? 1'b0 : 1'b1, "R11 full count after restart");
    end
    check(bus_irq_pending, 1'b0, "R11 no pending");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=<20000", cycles);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule